// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetch Engine

This engine moves display frame data from memory into a downstream pixel FIFO. Software leaves the start of each transfer in memory as a chain of four-word descriptors. Each descriptor holds a link to the following descriptor, a source byte address, a frame tag and a command word. The command word carries a word count and a flag that marks the data as a palette load. The engine reads a descriptor, streams the words it names through fixed-size read bursts, reports that the descriptor is done, and then follows the link.

A descriptor that links to itself makes the engine refetch one frame indefinitely. A palette descriptor and a frame descriptor that link to each other make palette and frame loads alternate. In dual-scan mode a second chain, with its own head address, feeds the lower half of the panel. The two chains take turns one descriptor at a time and share a single memory read port. Every word pushed into the FIFO carries a channel tag.

Top module: `dma_desc_fetch`

## Requirements
- R1: While reset is asserted, `memReq`, `pushValid` and `frameDone` are low and `frameId` is zero.
- R2: After `run` rises from idle, the first memory request is a 4-word read at the head address of channel 0.
- R3: Data words are pushed to the FIFO in address order, starting at the descriptor's source byte address. Each burst begins where the previous burst ended (address advances by 4 bytes per word), and no burst exceeds 16 words.
- R4: The last burst of a descriptor whose word count is not a multiple of 16 requests exactly the number of words that remain.
- R5: Command word bit 28 set marks the descriptor as a palette load. `pushPal` is 1 for every word pushed from such a descriptor and 0 for every other word. The word count is held in command bits 23:0.
- R6: After a descriptor completes, the next descriptor of that channel is fetched from the address held in descriptor word 0. A self-linked descriptor repeats its frame.
- R7: When a descriptor completes, `frameDone` pulses for one cycle with `frameId` equal to descriptor word 2 and `frameChan` equal to its channel. The pulse comes after the last data word of that descriptor has been pushed.
- R8: With `dualMode` high, descriptors alternate between channel 0 and channel 1, starting with channel 0. Each channel follows its own chain. `pushChan` and `frameChan` name the channel (0 or 1).
- R9: A data burst request is raised only when `fifoRoom` is at least the burst length. Once raised, `memReq`, `memAddr` and `memLen` hold steady until `memGnt` is seen.
- R10: A descriptor with a word count of zero pushes nothing, still pulses `frameDone`, and the chain continues.
- R11: When `run` is low at the point a descriptor completes, the engine goes idle and issues no further requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start (rising from idle) and keep fetching |
| dualMode | input | 1 | Alternate descriptors between two chains |
| headAddr0 | input | 32 | First descriptor byte address, channel 0 |
| headAddr1 | input | 32 | First descriptor byte address, channel 1 |
| memReq | output | 1 | Read burst request |
| memAddr | output | 32 | Burst start byte address |
| memLen | output | 5 | Burst length in words (1 to 16) |
| memGnt | input | 1 | Request accepted this cycle |
| memRdValid | input | 1 | Read data beat valid |
| memRdData | input | 32 | Read data beat |
| fifoRoom | input | 6 | Free FIFO entries |
| pushValid | output | 1 | Push a word into the FIFO |
| pushData | output | 32 | Word pushed |
| pushPal | output | 1 | Pushed word belongs to a palette load |
| pushChan | output | 1 | Channel of the pushed word |
| frameDone | output | 1 | One-cycle pulse when a descriptor completes |
| frameId | output | 32 | Frame tag of the completed descriptor |
| frameChan | output | 1 | Channel of the completed descriptor |

## Verification
A wrong descriptor field or a stale link shows up on the read port on the next request. That request can carry a wrong address or length, or a descriptor read can land in the wrong place. A broken remaining-word count or source pointer shows up within one burst, as a wrong address, a wrong length or wrongly ordered words at the FIFO. A wrong palette flag or a channel that fails to toggle shows up on the tags of the first word pushed for the affected descriptor. The bench keeps the full sequence of requests, pushes and completion pulses in order, so every one of these faults is caught close to where it first appears.

// File: rtl/dma_fetch_pkg.sv
package dma_fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DRD,
    ST_BWAIT,
    ST_BREQ,
    ST_BRD,
    ST_DONE
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic selDesc;
    logic loadHeads;
    logic descGrant;
    logic descBeat;
    logic burstGrant;
    logic dataBeat;
    logic finish;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic beatLast;
    logic lenZero;
    logic remZero;
    logic roomOk;
  } dpStatus_t;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import dma_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       dualMode,
  input  logic       memGnt,
  input  logic       memRdValid,
  input  dpStatus_t  stat,
  output ctlStrobe_t stb,
  output logic       memReq,
  output logic       chanSel
);

  fetchState_t state, nextState;

  always_comb begin
    stb         = '0;
    memReq      = 1'b0;
    nextState   = state;
    stb.selDesc = (state == ST_DREQ);
    unique case (state)
      ST_IDLE: begin
        if (run) begin
          stb.loadHeads = 1'b1;
          nextState     = ST_DREQ;
        end
      end
      ST_DREQ: begin
        memReq = 1'b1;
        if (memGnt) begin
          stb.descGrant = 1'b1;
          nextState     = ST_DRD;
        end
      end
      ST_DRD: begin
        if (memRdValid) begin
          stb.descBeat = 1'b1;
          if (stat.beatLast) nextState = stat.lenZero ? ST_DONE : ST_BWAIT;
        end
      end
      ST_BWAIT: begin
        // request rises only together with sufficient room
        if (stat.roomOk) begin
          memReq = 1'b1;
          if (memGnt) begin
            stb.burstGrant = 1'b1;
            nextState      = ST_BRD;
          end else begin
            nextState = ST_BREQ;
          end
        end
      end
      ST_BREQ: begin
        memReq = 1'b1;
        if (memGnt) begin
          stb.burstGrant = 1'b1;
          nextState      = ST_BRD;
        end
      end
      ST_BRD: begin
        if (memRdValid) begin
          stb.dataBeat = 1'b1;
          if (stat.beatLast) nextState = stat.remZero ? ST_DONE : ST_BWAIT;
        end
      end
      ST_DONE: begin
        stb.finish = 1'b1;
        nextState  = run ? ST_DREQ : ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      chanSel <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.loadHeads)                chanSel <= 1'b0;
      else if (stb.finish && dualMode)  chanSel <= ~chanSel;
    end
  end

endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath
  import dma_fetch_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 24,
  parameter int PAL_BIT   = 28,
  parameter int BURST_MAX = 16,
  parameter int ROOM_W    = 6,
  parameter int NCH       = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobe_t                   stb,
  input  logic                         chanSel,
  input  logic [NCH-1:0][ADDR_W-1:0]   headAddr,
  input  logic                         memRdValid,
  input  logic [DATA_W-1:0]            memRdData,
  input  logic [ROOM_W-1:0]            fifoRoom,
  output dpStatus_t                    stat,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [$clog2(BURST_MAX+1)-1:0] memLen,
  output logic                         pushValid,
  output logic [DATA_W-1:0]            pushData,
  output logic                         pushPal,
  output logic                         pushChan,
  output logic                         frameDone,
  output logic [DATA_W-1:0]            frameId,
  output logic                         frameChan
);

  localparam int BLEN_W     = $clog2(BURST_MAX + 1);
  localparam int DESC_WORDS = 4;

  logic [ADDR_W-1:0] descPtr [NCH];
  logic [ADDR_W-1:0] nextPtr, srcPtr;
  logic [DATA_W-1:0] idReg;
  logic [LEN_W-1:0]  remWords;
  logic              palFlag;
  logic [BLEN_W-1:0] beatCnt, curLen, burstLen;

  assign burstLen = (remWords > LEN_W'(BURST_MAX)) ? BLEN_W'(BURST_MAX)
                                                   : remWords[BLEN_W-1:0];

  assign memAddr = stb.selDesc ? descPtr[chanSel] : srcPtr;
  assign memLen  = stb.selDesc ? BLEN_W'(DESC_WORDS) : burstLen;

  assign stat.beatLast = memRdValid && (beatCnt == curLen - 1'b1);
  assign stat.lenZero  = (memRdData[LEN_W-1:0] == '0);
  assign stat.remZero  = (remWords == '0);
  assign stat.roomOk   = (32'(fifoRoom) >= 32'(burstLen));

  assign pushValid = stb.dataBeat;
  assign pushData  = memRdData;
  assign pushPal   = palFlag;
  assign pushChan  = chanSel;

  // one descriptor pointer per channel
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN)                                    descPtr[c] <= '0;
      else if (stb.loadHeads)                       descPtr[c] <= headAddr[c];
      else if (stb.finish && chanSel == 1'(c))      descPtr[c] <= nextPtr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPtr   <= '0;
      srcPtr    <= '0;
      idReg     <= '0;
      remWords  <= '0;
      palFlag   <= 1'b0;
      beatCnt   <= '0;
      curLen    <= '0;
      frameDone <= 1'b0;
      frameId   <= '0;
      frameChan <= 1'b0;
    end else begin
      frameDone <= stb.finish;
      if (stb.finish) begin
        frameId   <= idReg;
        frameChan <= chanSel;
      end
      if (stb.descGrant) begin
        beatCnt <= '0;
        curLen  <= BLEN_W'(DESC_WORDS);
      end else if (stb.burstGrant) begin
        beatCnt  <= '0;
        curLen   <= burstLen;
        srcPtr   <= srcPtr + (ADDR_W'(burstLen) << 2);
        remWords <= remWords - LEN_W'(burstLen);
      end else if (stb.descBeat || stb.dataBeat) begin
        beatCnt <= beatCnt + 1'b1;
      end
      if (stb.descBeat) begin
        unique case (beatCnt[1:0])
          2'd0: nextPtr <= memRdData[ADDR_W-1:0];
          2'd1: srcPtr  <= memRdData[ADDR_W-1:0];
          2'd2: idReg   <= memRdData;
          2'd3: begin
            remWords <= memRdData[LEN_W-1:0];
            palFlag  <= memRdData[PAL_BIT];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_fetch_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 24,
  parameter int PAL_BIT   = 28,
  parameter int BURST_MAX = 16,
  parameter int ROOM_W    = 6
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           run,
  input  logic                           dualMode,
  input  logic [ADDR_W-1:0]              headAddr0,
  input  logic [ADDR_W-1:0]              headAddr1,
  output logic                           memReq,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [$clog2(BURST_MAX+1)-1:0] memLen,
  input  logic                           memGnt,
  input  logic                           memRdValid,
  input  logic [DATA_W-1:0]              memRdData,
  input  logic [ROOM_W-1:0]              fifoRoom,
  output logic                           pushValid,
  output logic [DATA_W-1:0]              pushData,
  output logic                           pushPal,
  output logic                           pushChan,
  output logic                           frameDone,
  output logic [DATA_W-1:0]              frameId,
  output logic                           frameChan
);

  ctlStrobe_t ctlStb;
  dpStatus_t  dpStat;
  logic       chanSel;

  fetch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .run        (run),
    .dualMode   (dualMode),
    .memGnt     (memGnt),
    .memRdValid (memRdValid),
    .stat       (dpStat),
    .stb        (ctlStb),
    .memReq     (memReq),
    .chanSel    (chanSel)
  );

  fetch_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .PAL_BIT   (PAL_BIT),
    .BURST_MAX (BURST_MAX),
    .ROOM_W    (ROOM_W),
    .NCH       (2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (ctlStb),
    .chanSel    (chanSel),
    .headAddr   ({headAddr1, headAddr0}),
    .memRdValid (memRdValid),
    .memRdData  (memRdData),
    .fifoRoom   (fifoRoom),
    .stat       (dpStat),
    .memAddr    (memAddr),
    .memLen     (memLen),
    .pushValid  (pushValid),
    .pushData   (pushData),
    .pushPal    (pushPal),
    .pushChan   (pushChan),
    .frameDone  (frameDone),
    .frameId    (frameId),
    .frameChan  (frameChan)
  );

endmodule

// File: rtl/fetch_chk.sv
module fetch_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_BW = 5,
  parameter int ROOM_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memGnt,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LEN_BW-1:0] memLen,
  input logic              memRdValid,
  input logic [ROOM_W-1:0] fifoRoom,
  input logic              pushValid,
  input logic              frameDone,
  input logic              selDesc
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memLen));

  // R9
  room_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) && !selDesc |-> 32'(fifoRoom) >= 32'(memLen));

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memLen != '0) && (32'(memLen) <= 16));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R7
  done_after_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !pushValid);

  // R3
  push_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> memRdValid);

endmodule

bind dma_desc_fetch fetch_chk #(
  .ADDR_W (ADDR_W),
  .LEN_BW ($clog2(BURST_MAX+1)),
  .ROOM_W (ROOM_W)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .memReq     (memReq),
  .memGnt     (memGnt),
  .memAddr    (memAddr),
  .memLen     (memLen),
  .memRdValid (memRdValid),
  .fifoRoom   (fifoRoom),
  .pushValid  (pushValid),
  .frameDone  (frameDone),
  .selDesc    (ctlStb.selDesc)
);

// File: tb/tb_dma_desc_fetch.sv
module tb_dma_desc_fetch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic        dualMode = 1'b0;
  logic [31:0] headAddr0 = '0, headAddr1 = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic [4:0]  memLen;
  logic        memGnt = 1'b0;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic [5:0]  fifoRoom = '0;
  logic        pushValid, pushPal, pushChan, frameDone, frameChan;
  logic [31:0] pushData, frameId;

  always #5 clk = ~clk;

  dma_desc_fetch dut (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [31:0] memW [1024];

  logic [37:0] expReq[$];   // {isDesc, addr, len}
  logic [36:0] obsReq[$];   // {addr, len}
  logic [33:0] expPush[$], obsPush[$]; // {data, pal, chan}
  logic [33:0] expFrm[$];   // {zeroLen, id, chan}
  logic [32:0] obsFrm[$];   // {id, chan}
  logic [31:0] pend[$];
  bit monOn = 0;
  bit prevReq = 0, prevGnt = 0;
  logic [31:0] prevAddr;
  logic [4:0]  prevLen;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent walk of the descriptor chains
  task automatic buildExpected(logic [31:0] h0, logic [31:0] h1, bit dual, int k);
    logic [31:0] ptr [2];
    int ch = 0;
    expReq.delete(); expPush.delete(); expFrm.delete();
    ptr[0] = h0; ptr[1] = h1;
    for (int n = 0; n < k; n++) begin
      logic [31:0] d, nxt, src, id, cmd;
      int rem;
      d   = ptr[ch];
      nxt = memW[d[11:2]];
      src = memW[d[11:2] + 1];
      id  = memW[d[11:2] + 2];
      cmd = memW[d[11:2] + 3];
      rem = int'(cmd[23:0]);
      expReq.push_back({1'b1, d, 5'd4});
      while (rem > 0) begin
        int b = (rem > 16) ? 16 : rem;
        expReq.push_back({1'b0, src, 5'(b)});
        for (int i = 0; i < b; i++) begin
          logic [31:0] a = src + 32'(4 * i);
          expPush.push_back({memW[a[11:2]], cmd[28], 1'(ch)});
        end
        src = src + 32'(4 * b);
        rem -= b;
      end
      expFrm.push_back({cmd[23:0] == 0, id, 1'(ch)});
      ptr[ch] = nxt;
      if (dual) ch ^= 1;
    end
  endtask

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    if (rstN && monOn) begin
      if (pushValid) obsPush.push_back({pushData, pushPal, pushChan});
      if (frameDone) obsFrm.push_back({frameId, frameChan});
      if (prevReq && !prevGnt)
        check(memReq && memAddr == prevAddr && memLen == prevLen, "R9 hold",
              {memReq, memAddr, memLen}, {1'b1, prevAddr, prevLen});
      if (memReq && !prevReq && obsReq.size() < expReq.size())
        if (!expReq[obsReq.size()][37])
          check(32'(fifoRoom) >= 32'(memLen), "R9 room", fifoRoom, memLen);
      if (memReq && memGnt) begin
        obsReq.push_back({memAddr, memLen});
        for (int i = 0; i < int'(memLen); i++) pend.push_back(memAddr + 32'(4 * i));
      end
      prevReq = memReq; prevGnt = memGnt; prevAddr = memAddr; prevLen = memLen;
    end
  end

  // memory and FIFO-room responder
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rstN) begin
        memGnt = 0; memRdValid = 0; fifoRoom = '0;
      end else begin
        memGnt   = ($urandom % 3) != 0;
        fifoRoom = (($urandom % 4) == 0) ? 6'd40 : 6'($urandom_range(0, 31));
        if (pend.size() > 0 && ($urandom % 4) != 0) begin
          memRdValid = 1;
          memRdData  = memW[pend[0][11:2]];
          void'(pend.pop_front());
        end else begin
          memRdValid = 0;
          memRdData  = $urandom;
        end
      end
    end
  end

  task automatic setDesc(int a, logic [31:0] nxt, logic [31:0] src, logic [31:0] id, logic [31:0] cmd);
    memW[a/4] = nxt; memW[a/4 + 1] = src; memW[a/4 + 2] = id; memW[a/4 + 3] = cmd;
  endtask

  task automatic runTest(logic [31:0] h0, logic [31:0] h1, bit dual, int k);
    bit quiet = 1;
    int n;
    buildExpected(h0, h1, dual, k);
    obsReq.delete(); obsPush.delete(); obsFrm.delete();
    prevReq = 0; prevGnt = 0;
    @(posedge clk); #1;
    headAddr0 = h0; headAddr1 = h1; dualMode = dual; monOn = 1; run = 1;
    while (obsFrm.size() < k - 1) @(posedge clk);
    #1 run = 0;
    while (obsFrm.size() < k) @(posedge clk);
    repeat (40) begin
      @(negedge clk);
      if (memReq) quiet = 0;
    end
    check(quiet, "R11 idle after stop", memReq, 0);
    monOn = 0;
    check(obsReq.size() == expReq.size(), "R6 request count", obsReq.size(), expReq.size());
    n = (obsReq.size() < expReq.size()) ? obsReq.size() : expReq.size();
    for (int i = 0; i < n; i++) begin
      string tag = (i == 0) ? "R2 first request" :
                   expReq[i][37] ? "R6 descriptor fetch" :
                   (expReq[i][4:0] < 16) ? "R4 tail burst" : "R3 burst";
      check(obsReq[i] == expReq[i][36:0], tag, obsReq[i], expReq[i][36:0]);
    end
    check(obsPush.size() == expPush.size(), "R3 push count", obsPush.size(), expPush.size());
    n = (obsPush.size() < expPush.size()) ? obsPush.size() : expPush.size();
    for (int i = 0; i < n; i++) begin
      check(obsPush[i][33:2] == expPush[i][33:2], "R3 data", obsPush[i][33:2], expPush[i][33:2]);
      check(obsPush[i][1] == expPush[i][1], "R5 palette tag", obsPush[i][1], expPush[i][1]);
      check(obsPush[i][0] == expPush[i][0], "R8 push channel", obsPush[i][0], expPush[i][0]);
    end
    check(obsFrm.size() == expFrm.size(), "R7 frame count", obsFrm.size(), expFrm.size());
    n = (obsFrm.size() < expFrm.size()) ? obsFrm.size() : expFrm.size();
    for (int i = 0; i < n; i++) begin
      check(obsFrm[i][32:1] == expFrm[i][32:1], expFrm[i][33] ? "R10 empty descriptor id" : "R7 frame id",
            obsFrm[i][32:1], expFrm[i][32:1]);
      check(obsFrm[i][0] == expFrm[i][0], "R8 frame channel", obsFrm[i][0], expFrm[i][0]);
    end
  endtask

  initial begin
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < 1024; i++) memW[i] = $urandom;
    // palette <-> frame pair
    setDesc(32'h010, 32'h020, 32'h200, 32'h0000_00a1, (32'd1 << 28) | 32'd5);
    setDesc(32'h020, 32'h010, 32'h300, 32'h0000_00b2, 32'd37);
    // self-linked frame, exact burst multiple
    setDesc(32'h040, 32'h040, 32'h500, 32'h0000_00c3, 32'd16);
    // dual scan: upper self-linked, lower with an empty descriptor
    setDesc(32'h050, 32'h050, 32'h600, 32'h0000_00d0, 32'd7);
    setDesc(32'h060, 32'h070, 32'h700, 32'h0000_00e0, 32'd18);
    setDesc(32'h070, 32'h060, 32'h900, 32'h0000_00e1, 32'd0);
    // full palette load, self-linked
    setDesc(32'h080, 32'h080, 32'h800, 32'h0000_00f4, (32'd1 << 28) | 32'd128);

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(!memReq && !pushValid && !frameDone && frameId == 0, "R1 reset state",
          {memReq, pushValid, frameDone, frameId}, 0);
    @(posedge clk); #1 rstN = 1;

    runTest(32'h010, 32'h0, 1'b0, 4);   // R5 alternating palette/frame, R4 tail
    runTest(32'h040, 32'h0, 1'b0, 3);   // R6 self-link repeat
    runTest(32'h050, 32'h060, 1'b1, 6); // R8 dual chains, R10 empty descriptor
    runTest(32'h080, 32'h0, 1'b0, 2);   // R3 long palette load in full bursts
    runTest(32'h020, 32'h050, 1'b0, 2); // channel 1 head ignored when not dual

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule